// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block derives the SCL clock waveform of an I2C master from a fast system clock. A power-of-two prescaler turns the system clock into ticks, and two phase counters count those ticks, one for the low half and one for the high half of each SCL period. Each phase length is held as its tick count minus one, so the SCL period is 2^base × ((high + 1) + (low + 1)) system clocks. A byte engine next to this block reads two one-cycle strobes. One marks the start of every low phase, which is where SDA may change. The other marks the middle of every high phase, which is where SDA is sampled.

The block keeps one 32-bit timing word. Bits 3:0 hold the base divisor, bits 19:16 the high count and bits 15:12 the low count. The upper twelve bits hold the bus-free, start-hold and setup timings, which are kept and shown on `cfg_word` but do not affect SCL. A full write replaces the whole word. A clock-only write replaces just the base and phase fields. The parameter `PHASE_W` chooses between 4-bit phase fields, with a largest combined count of 32, and 3-bit phase fields, with a largest combined count of 16. A target may hold SCL low during the high phase, and the high count then waits until the line is seen high again.

The controller has four states: `SCL_OFF` (disabled, SCL released), `SCL_LOW` (SCL driven low), `SCL_HIGH` (SCL released and counting) and `SCL_HOLD` (SCL released but sensed low, so the count is frozen). Its transitions are:
- `SCL_OFF` to `SCL_LOW` when enable is seen high.
- `SCL_LOW` to `SCL_HIGH` when the low count is done.
- `SCL_HIGH` to `SCL_LOW` when the high count is done.
- `SCL_HIGH` to `SCL_HOLD` when SCL is sensed low.
- `SCL_HOLD` to `SCL_HIGH` when SCL is sensed high.
- Any state to `SCL_OFF` when enable is low.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, and in the cycle after enable is seen low, `scl_drive_low`, `sample_stb` and `change_stb` are all 0.
- R2: The timing word holds the base divisor in bits 3:0, the high count in bits 19:16 and the low count in bits 15:12. Bits 11:4 and 31:20 have no effect on the SCL waveform.
- R3: Each low phase holds `scl_drive_low` at 1 for exactly 2^base × (low + 1) system clocks.
- R4: An unstretched high phase holds `scl_drive_low` at 0 for exactly 2^base × (high + 1) system clocks. The phases then keep alternating.
- R5: The first clock edge that sees enable high starts a low phase, so `scl_drive_low` is 1 in the next cycle.
- R6: `change_stb` is 1 for exactly one cycle per low phase, in its first cycle.
- R7: `sample_stb` is 1 for exactly one cycle per high phase. In an unstretched high phase that cycle is 2^base × ((high + 1) >> 1) clocks after the first high cycle.
- R8: While `scl_sense` is low during the high phase, the high count is frozen and the tick in progress restarts. If SCL is sensed low on k consecutive edges starting with the first edge of the high phase, the high phase becomes k + 1 clocks longer and `sample_stb` moves later by the same amount.
- R9: A clock-only write replaces bits 19:12 and 3:0 and leaves bits 31:20 and 11:4 as they were. A full write replaces all 32 bits. When both writes are requested together, the full write wins.
- R10: Removing enable in the middle of a phase releases SCL. Enabling again starts a fresh, full-length low phase.
- R11: A base divisor of 15 gives ticks 32768 system clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the SCL generator while high |
| cfg_wr_all | input | 1 | Writes all 32 bits of the timing word |
| cfg_wr_clk | input | 1 | Writes only the base and phase fields |
| cfg_wdata | input | 32 | Write data for the timing word |
| scl_sense | input | 1 | Sensed level of the SCL line |
| cfg_word | output | 32 | Current timing word |
| scl_drive_low | output | 1 | 1 requests that SCL be pulled low |
| sample_stb | output | 1 | One-cycle strobe at the middle of the high phase |
| change_stb | output | 1 | One-cycle strobe at the start of the low phase |

## Verification
Random timing words with base 0 to 3 and every phase count from 0 to 15 check the prescaler and phase lengths against the period formula. Random content in the unused bits shows that those bits have no effect. High counts of 0 and 1 separate a strobe placed at the start of the high phase from one at its middle, and a base of 15 checks the widest prescale. Stretches of several lengths show a frozen count, as opposed to a restarted or ignored one, because the high length and the strobe position move by exactly the expected number of clocks. Directed writes check which fields each write kind replaces, and removing enable in the middle of a phase checks the release and the fresh restart.

// File: rtl/scl_tim_pkg.sv
package scl_tim_pkg;

    localparam int CFG_W      = 32;
    localparam int BASE_LSB   = 0;
    localparam int LOW_LSB    = 12;
    localparam int HIGH_LSB   = 16;
    localparam int CLK_FLD_HI = 19;
    localparam int RSV_HI_LSB = 20;

    typedef enum logic [1:0] {
        SCL_OFF  = 2'd0,
        SCL_LOW  = 2'd1,
        SCL_HIGH = 2'd2,
        SCL_HOLD = 2'd3
    } scl_state_e;

endpackage

// File: rtl/scl_cfg_store.sv
module scl_cfg_store
    import scl_tim_pkg::*;
#(
    parameter int PHASE_W = 4,
    parameter int BASE_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_all,
    input  logic               wr_clk,
    input  logic [CFG_W-1:0]   wdata,
    output logic [CFG_W-1:0]   word_q,
    output logic [BASE_W-1:0]  base_div,
    output logic [PHASE_W-1:0] high_len,
    output logic [PHASE_W-1:0] low_len
);

    localparam logic [CFG_W-1:0] CLK_MASK =
        (((CFG_W)'(1) << (CLK_FLD_HI + 1)) - ((CFG_W)'(1) << LOW_LSB))
        | (((CFG_W)'(1) << BASE_W) - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (wr_all) begin
            word_q <= wdata;
        end else if (wr_clk) begin
            word_q <= (word_q & ~CLK_MASK) | (wdata & CLK_MASK);
        end
    end

    assign base_div = word_q[BASE_LSB +: BASE_W];

    generate
        if (PHASE_W >= 4) begin : g_wide
            assign high_len = word_q[HIGH_LSB +: PHASE_W];
            assign low_len  = word_q[LOW_LSB  +: PHASE_W];
        end else begin : g_narrow
            assign high_len = word_q[HIGH_LSB +: PHASE_W];
            assign low_len  = word_q[LOW_LSB  +: PHASE_W];
        end
    endgenerate

    // R9
    keep_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clk && !wr_all) |=> $stable(word_q[CFG_W-1:RSV_HI_LSB]));

    // R9
    keep_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clk && !wr_all) |=> $stable(word_q[LOW_LSB-1:BASE_W]));

endmodule

// File: rtl/scl_prescale.sv
module scl_prescale #(
    parameter int BASE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [BASE_W-1:0] base_div,
    output logic              tick,
    output logic              at_zero
);

    localparam int PRE_W = (1 << BASE_W) - 1;

    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W:0]   span;
    logic [PRE_W-1:0] lim;

    always_comb begin
        span = (PRE_W + 1)'(1) << base_div;
        lim  = PRE_W'(span - 1'b1);
    end

    assign tick    = run && (cnt_q >= lim);
    assign at_zero = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3
    tick_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == '0));

    // R8
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> at_zero);

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_tim_pkg::*;
#(
    parameter int PHASE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               scl_in,
    input  logic               tick,
    input  logic               pre_zero,
    input  logic [PHASE_W-1:0] high_len,
    input  logic [PHASE_W-1:0] low_len,
    output logic               pre_run,
    output logic               scl_drive_low,
    output logic               sample_stb,
    output logic               change_stb
);

    scl_state_e         state_q, state_d;
    logic [PHASE_W-1:0] ph_cnt_q;
    logic               first_low_q;
    logic               smp_done_q;
    logic [PHASE_W:0]   mid_pt;
    logic               low_done, high_done;

    assign mid_pt    = ((PHASE_W + 1)'(high_len) + 1'b1) >> 1;
    assign low_done  = tick && (ph_cnt_q >= low_len);
    assign high_done = tick && (ph_cnt_q >= high_len);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SCL_OFF:  state_d = enable ? SCL_LOW : SCL_OFF;
            SCL_LOW: begin
                if (!enable)       state_d = SCL_OFF;
                else if (low_done) state_d = SCL_HIGH;
            end
            SCL_HIGH: begin
                if (!enable)        state_d = SCL_OFF;
                else if (!scl_in)   state_d = SCL_HOLD;
                else if (high_done) state_d = SCL_LOW;
            end
            SCL_HOLD: begin
                if (!enable)     state_d = SCL_OFF;
                else if (scl_in) state_d = SCL_HIGH;
            end
            default: state_d = SCL_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= SCL_OFF;
            ph_cnt_q    <= '0;
            first_low_q <= 1'b0;
            smp_done_q  <= 1'b0;
        end else begin
            state_q     <= state_d;
            first_low_q <= (state_d == SCL_LOW) && (state_q != SCL_LOW);
            if ((state_d == SCL_OFF) ||
                (state_d == SCL_LOW  && state_q != SCL_LOW) ||
                (state_d == SCL_HIGH && state_q == SCL_LOW)) begin
                ph_cnt_q <= '0;
            end else if (tick) begin
                ph_cnt_q <= ph_cnt_q + 1'b1;
            end
            if (state_d != SCL_HIGH && state_d != SCL_HOLD) begin
                smp_done_q <= 1'b0;
            end else if (sample_stb) begin
                smp_done_q <= 1'b1;
            end
        end
    end

    always_comb begin
        pre_run       = enable && ((state_q == SCL_LOW) ||
                                   (state_q == SCL_HIGH && scl_in));
        scl_drive_low = (state_q == SCL_LOW);
        change_stb    = (state_q == SCL_LOW) && first_low_q;
        sample_stb    = (state_q == SCL_HIGH) && scl_in && !smp_done_q &&
                        pre_zero && ((PHASE_W + 1)'(ph_cnt_q) == mid_pt);
    end

    // R1
    off_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!scl_drive_low && !sample_stb && !change_stb));

    // R6
    change_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        change_stb |=> !change_stb);

    // R8
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SCL_HOLD && enable) |=> $stable(ph_cnt_q));

    // R7
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sample_stb, change_stb}));

    // R7
    sample_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> !sample_stb);

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_tim_pkg::*;
#(
    parameter int PHASE_W = 4,
    parameter int BASE_W  = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic        cfg_wr_all,
    input  logic        cfg_wr_clk,
    input  logic [31:0] cfg_wdata,
    input  logic        scl_sense,
    output logic [31:0] cfg_word,
    output logic        scl_drive_low,
    output logic        sample_stb,
    output logic        change_stb
);

    logic [BASE_W-1:0]  base_div;
    logic [PHASE_W-1:0] high_len;
    logic [PHASE_W-1:0] low_len;
    logic               pre_run;
    logic               tick;
    logic               pre_zero;

    scl_cfg_store #(.PHASE_W(PHASE_W), .BASE_W(BASE_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_all   (cfg_wr_all),
        .wr_clk   (cfg_wr_clk),
        .wdata    (cfg_wdata),
        .word_q   (cfg_word),
        .base_div (base_div),
        .high_len (high_len),
        .low_len  (low_len)
    );

    scl_prescale #(.BASE_W(BASE_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (pre_run),
        .base_div (base_div),
        .tick     (tick),
        .at_zero  (pre_zero)
    );

    scl_phase_fsm #(.PHASE_W(PHASE_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .scl_in        (scl_sense),
        .tick          (tick),
        .pre_zero      (pre_zero),
        .high_len      (high_len),
        .low_len       (low_len),
        .pre_run       (pre_run),
        .scl_drive_low (scl_drive_low),
        .sample_stb    (sample_stb),
        .change_stb    (change_stb)
    );

    // R5
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !$past(enable) && !scl_drive_low && !$past(scl_drive_low))
        |=> scl_drive_low);

endmodule

// File: tb/scl_timing_gen_tb.sv
module scl_timing_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        cfg_wr_all = 1'b0;
    logic        cfg_wr_clk = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        stretch = 1'b0;
    logic        scl_sense;
    logic [31:0] cfg_word;
    logic        scl_drive_low, sample_stb, change_stb;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    assign scl_sense = ~(scl_drive_low | stretch);

    scl_timing_gen u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .cfg_wr_all    (cfg_wr_all),
        .cfg_wr_clk    (cfg_wr_clk),
        .cfg_wdata     (cfg_wdata),
        .scl_sense     (scl_sense),
        .cfg_word      (cfg_word),
        .scl_drive_low (scl_drive_low),
        .sample_stb    (sample_stb),
        .change_stb    (change_stb)
    );

    function automatic int exp_low(int b, int l);
        return (1 << b) * (l + 1);
    endfunction

    function automatic int exp_high(int b, int h, int k);
        return (1 << b) * (h + 1) + ((k > 0) ? k + 1 : 0);
    endfunction

    function automatic int exp_spos(int b, int h, int k);
        return 1 + ((k > 0) ? k + 1 : 0) + (1 << b) * ((h + 1) >> 1);
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input bit all, input bit clk_only, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_all = all;
        cfg_wr_clk = clk_only;
        cfg_wdata  = d;
        @(negedge clk);
        cfg_wr_all = 1'b0;
        cfg_wr_clk = 1'b0;
    endtask

    // R2 R3 R4 R5 R6 R7 R8: one period with fields placed at bits 3:0, 15:12, 19:16
    task automatic run_case(input int b, input int h, input int l, input int k);
        logic [31:0] w;
        int lc, hc, sc, spos, cc;
        @(negedge clk);
        enable = 1'b0;
        w = $urandom;
        w[3:0]   = 4'(b);
        w[15:12] = 4'(l);
        w[19:16] = 4'(h);
        write_cfg(1'b1, 1'b0, w);
        enable = 1'b1;
        @(negedge clk);
        chk(scl_drive_low == 1'b1, "R5 low phase starts after enable", scl_drive_low, 1);
        lc = 0; cc = 0;
        while (scl_drive_low) begin
            lc++;
            if (change_stb) cc++;
            if (lc == 1) chk(change_stb == 1'b1, "R6 change strobe at low start", change_stb, 1);
            @(negedge clk);
        end
        chk(lc == exp_low(b, l), "R3 low phase length", lc, exp_low(b, l));
        chk(cc == 1, "R6 change strobe count", cc, 1);
        hc = 0; sc = 0; spos = 0;
        while (!scl_drive_low && hc < 70000) begin
            hc++;
            if (sample_stb) begin sc++; spos = hc; end
            if (hc == 1 && k > 0) stretch = 1'b1;
            if (k > 0 && hc == k + 1) stretch = 1'b0;
            @(negedge clk);
        end
        stretch = 1'b0;
        chk(hc == exp_high(b, h, k), (k > 0) ? "R8 stretched high length" : "R4 high phase length",
            hc, exp_high(b, h, k));
        chk(sc == 1, "R7 sample strobe count", sc, 1);
        chk(spos == exp_spos(b, h, k), (k > 0) ? "R8 sample strobe moved" : "R7 sample strobe position",
            spos, exp_spos(b, h, k));
        chk(scl_drive_low && change_stb, "R6 change strobe on next low", {scl_drive_low, change_stb}, 3);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        chk({scl_drive_low, sample_stb, change_stb} == 3'b0, "R1 reset outputs", {scl_drive_low, sample_stb, change_stb}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cfg_word == 32'h0, "R1 reset word", cfg_word, 0);

        // R9 write kinds
        write_cfg(1'b1, 1'b0, 32'hA5C3_F7E2);
        chk(cfg_word == 32'hA5C3_F7E2, "R9 full write", cfg_word, 32'hA5C3_F7E2);
        write_cfg(1'b0, 1'b1, 32'h1234_5678);
        chk(cfg_word == 32'hA5C4_57E8, "R9 clock-only write", cfg_word, 32'hA5C4_57E8);
        write_cfg(1'b1, 1'b1, 32'h0F0F_0F0F);
        chk(cfg_word == 32'h0F0F_0F0F, "R9 full write wins", cfg_word, 32'h0F0F_0F0F);

        // directed corners
        run_case(0, 0, 0, 0);
        run_case(0, 1, 0, 0);
        run_case(2, 15, 15, 0);
        run_case(1, 3, 2, 4);
        run_case(0, 1, 1, 1);

        // R10 disable mid-phase and restart
        run_case(2, 2, 3, 0);
        repeat (2) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk({scl_drive_low, sample_stb, change_stb} == 3'b0, "R10 release on disable",
            {scl_drive_low, sample_stb, change_stb}, 0);
        chk({scl_drive_low, sample_stb, change_stb} == 3'b0, "R1 disabled outputs",
            {scl_drive_low, sample_stb, change_stb}, 0);
        enable = 1'b1;
        begin
            int lc2 = 0;
            @(negedge clk);
            while (scl_drive_low) begin lc2++; @(negedge clk); end
            chk(lc2 == exp_low(2, 3), "R10 fresh low after re-enable", lc2, exp_low(2, 3));
        end

        // constrained random, R2 also covers random bits 11:4 and 31:20
        for (int i = 0; i < 24; i++) begin
            int b = int'($urandom_range(0, 3));
            int h = int'($urandom_range(0, 15));
            int l = int'($urandom_range(0, 15));
            int k = (h >= 1 && ($urandom_range(0, 1) == 1)) ? int'($urandom_range(1, 6)) : 0;
            run_case(b, h, l, k);
        end

        // R11 widest prescale
        run_case(15, 0, 0, 0);
        chk(1'b1 && exp_low(15, 0) == 32768, "R11 tick spacing", exp_low(15, 0), 32768);

        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule